// File: doc/BRIEF.md
# DS3 Serial Transmit Payload Port

This block is the transmit-side payload entry point of a DS3 framer. It runs in serial mode, takes its timing from the local transmit clock, and acts as the frame-timing master. A single 44.736 MHz clock drives both this block and the upstream terminal equipment. The upstream equipment launches one payload bit per clock on the rising edge. The block latches that bit on the next rising edge, so the data arrives one cycle after it is launched.

The block counts its own position within the 4760-bit DS3 M-frame. The frame is made of 7 subframes, each of 8 blocks, and each block holds 85 bits. For one clock period the block raises an end-of-frame strobe toward the source. The source then launches bit 0 of the next frame. The block hands each sampled bit to the downstream frame builder, together with its subframe, block and bit indices. It also gives a payload-valid flag and an overhead flag. The first bit of every 85-bit block is reserved for overhead, so the payload value latched there is marked as not valid.

Top module: `ds3_tx_serial_port`

## Requirements
- R1: While rst_ni is low and before the first rising clock edge after its release, eof_o, oh_ind_o, data_valid_o, data_o, sf_idx_o, blk_idx_o and bit_idx_o are all 0.
- R2: After each rising edge, data_o equals the value ser_data_i had at that edge.
- R3: The k-th edge after reset release (k counting from 1) latches frame position p = (k-1) mod 4760. After that edge, bit_idx_o = p mod 85, blk_idx_o = (p div 85) mod 8 and sf_idx_o = p div 680. The bit index therefore moves fastest, then the block index, then the subframe index.
- R4: The position after subframe 6, block 7, bit 84 is subframe 0, block 0, bit 0. The frame length is 4760 bits.
- R5: eof_o is high during exactly one clock period per frame. This is the period that ends with the edge latching position 4759 (6,7,84). The first such period follows edge 4759 after reset release. eof_o is low in every other period.
- R6: The edge that ends an eof_o high period latches the last bit of the frame. The next edge latches bit 0 of block 0 of subframe 0, which is the bit the source launched when it saw the strobe.
- R7: After an edge that latched bit index 0, oh_ind_o is 1 and data_valid_o is 0. After an edge that latched bit index 1 to 84, oh_ind_o is 0 and data_valid_o is 1.
- R8: The value of ser_data_i has no effect on eof_o, oh_ind_o, data_valid_o or the indices. At overhead positions, data_o still carries the latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 44.736 MHz transmit clock, shared with the source |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial payload bit from the upstream source |
| eof_o | output | 1 | End-of-frame strobe toward the source |
| oh_ind_o | output | 1 | Latched bit sits at an overhead position |
| data_valid_o | output | 1 | Latched bit is payload |
| data_o | output | 1 | Latched serial bit |
| sf_idx_o | output | 3 | Subframe index of the latched bit |
| blk_idx_o | output | 3 | Block index of the latched bit |
| bit_idx_o | output | 7 | Bit index within the block of the latched bit |

## Verification
The serial input is driven with four patterns in turn: constant ones, constant zeros, an alternating pattern, and a pseudo-random sequence. The constant patterns expose a stuck or inverted data path. Alternating data exposes an extra or missing cycle of latency. The random sequence shows that the strobes and indices do not depend on the data.

The run covers two full frames. It therefore checks both the first end-of-frame strobe after reset and the strobe one full frame later, where the counter wraps. A reset in mid-frame followed by a fresh count shows that position tracking restarts from zero.

// File: rtl/ds3_tx_pkg.sv
package ds3_tx_pkg;
  localparam int unsigned BLOCK_BITS    = 85;
  localparam int unsigned BLOCKS_PER_SF = 8;
  localparam int unsigned SUBFRAMES     = 7;
  localparam int unsigned FRAME_BITS    = BLOCK_BITS * BLOCKS_PER_SF * SUBFRAMES;
endpackage

// File: rtl/ds3_pos_counter.sv
// Nested position counter: bit within block, block within subframe, subframe.
module ds3_pos_counter #(
  parameter int unsigned BLOCK_BITS    = ds3_tx_pkg::BLOCK_BITS,
  parameter int unsigned BLOCKS_PER_SF = ds3_tx_pkg::BLOCKS_PER_SF,
  parameter int unsigned SUBFRAMES     = ds3_tx_pkg::SUBFRAMES,
  localparam int unsigned BIT_W = $clog2(BLOCK_BITS),
  localparam int unsigned BLK_W = $clog2(BLOCKS_PER_SF),
  localparam int unsigned SF_W  = $clog2(SUBFRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [SF_W-1:0]  sf_q_o,
  output logic [BLK_W-1:0] blk_q_o,
  output logic [BIT_W-1:0] bit_q_o,
  output logic             last_next_o
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BLOCK_BITS - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCKS_PER_SF - 1);
  localparam logic [SF_W-1:0]  SF_LAST  = SF_W'(SUBFRAMES - 1);

  logic [SF_W-1:0]  sf_q,  sf_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic bit_wrap, blk_wrap, sf_wrap;

  assign bit_wrap = (bit_q == BIT_LAST);
  assign blk_wrap = bit_wrap && (blk_q == BLK_LAST);
  assign sf_wrap  = blk_wrap && (sf_q == SF_LAST);

  always_comb begin
    bit_d = bit_wrap ? '0 : bit_q + 1'b1;
    blk_d = blk_q;
    sf_d  = sf_q;
    if (bit_wrap) blk_d = (blk_q == BLK_LAST) ? '0 : blk_q + 1'b1;
    if (blk_wrap) sf_d  = sf_wrap ? '0 : sf_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      blk_q <= '0;
      sf_q  <= '0;
    end else begin
      bit_q <= bit_d;
      blk_q <= blk_d;
      sf_q  <= sf_d;
    end
  end

  assign sf_q_o      = sf_q;
  assign blk_q_o     = blk_q;
  assign bit_q_o     = bit_q;
  assign last_next_o = (bit_d == BIT_LAST) && (blk_d == BLK_LAST) && (sf_d == SF_LAST);

  a_r4_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_q == BIT_LAST && blk_q == BLK_LAST && sf_q == SF_LAST)
      |=> (bit_q == '0 && blk_q == '0 && sf_q == '0));

  a_r3_bit_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_q <= BIT_LAST) && (blk_q <= BLK_LAST) && (sf_q <= SF_LAST));

  a_r3_block_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_q != BIT_LAST) |=> $stable(blk_q) && $stable(sf_q));
endmodule

// File: rtl/ds3_strobe_gen.sv
// Registered end-of-frame strobe, high while the last bit is awaited.
module ds3_strobe_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic last_next_i,
  output logic eof_o
);
  logic eof_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eof_q <= 1'b0;
    else         eof_q <= last_next_i;
  end

  assign eof_o = eof_q;

  a_r5_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_q |=> !eof_q);
endmodule

// File: rtl/ds3_payload_reg.sv
// Latches the serial bit with the position it occupied.
module ds3_payload_reg #(
  parameter int unsigned BIT_W = 7,
  parameter int unsigned BLK_W = 3,
  parameter int unsigned SF_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_data_i,
  input  logic [SF_W-1:0]  sf_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [BIT_W-1:0] bit_i,
  output logic             data_o,
  output logic             data_valid_o,
  output logic             oh_ind_o,
  output logic [SF_W-1:0]  sf_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [BIT_W-1:0] bit_o
);
  logic oh_pos;
  assign oh_pos = (bit_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o       <= 1'b0;
      data_valid_o <= 1'b0;
      oh_ind_o     <= 1'b0;
      sf_o         <= '0;
      blk_o        <= '0;
      bit_o        <= '0;
    end else begin
      data_o       <= ser_data_i;
      data_valid_o <= !oh_pos;
      oh_ind_o     <= oh_pos;
      sf_o         <= sf_i;
      blk_o        <= blk_i;
      bit_o        <= bit_i;
    end
  end

  a_r7_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(oh_ind_o && data_valid_o));

  a_r2_data_follows_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_data_i |=> data_o);
endmodule

// File: rtl/ds3_tx_serial_port.sv
module ds3_tx_serial_port #(
  parameter int unsigned BLOCK_BITS    = ds3_tx_pkg::BLOCK_BITS,
  parameter int unsigned BLOCKS_PER_SF = ds3_tx_pkg::BLOCKS_PER_SF,
  parameter int unsigned SUBFRAMES     = ds3_tx_pkg::SUBFRAMES,
  localparam int unsigned BIT_W = $clog2(BLOCK_BITS),
  localparam int unsigned BLK_W = $clog2(BLOCKS_PER_SF),
  localparam int unsigned SF_W  = $clog2(SUBFRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_data_i,
  output logic             eof_o,
  output logic             oh_ind_o,
  output logic             data_valid_o,
  output logic             data_o,
  output logic [SF_W-1:0]  sf_idx_o,
  output logic [BLK_W-1:0] blk_idx_o,
  output logic [BIT_W-1:0] bit_idx_o
);
  logic [SF_W-1:0]  sf_q;
  logic [BLK_W-1:0] blk_q;
  logic [BIT_W-1:0] bit_q;
  logic             last_next;

  ds3_pos_counter #(
    .BLOCK_BITS   (BLOCK_BITS),
    .BLOCKS_PER_SF(BLOCKS_PER_SF),
    .SUBFRAMES    (SUBFRAMES)
  ) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sf_q_o     (sf_q),
    .blk_q_o    (blk_q),
    .bit_q_o    (bit_q),
    .last_next_o(last_next)
  );

  ds3_strobe_gen u_eof (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .last_next_i(last_next),
    .eof_o      (eof_o)
  );

  ds3_payload_reg #(
    .BIT_W(BIT_W),
    .BLK_W(BLK_W),
    .SF_W (SF_W)
  ) u_pay (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ser_data_i  (ser_data_i),
    .sf_i        (sf_q),
    .blk_i       (blk_q),
    .bit_i       (bit_q),
    .data_o      (data_o),
    .data_valid_o(data_valid_o),
    .oh_ind_o    (oh_ind_o),
    .sf_o        (sf_idx_o),
    .blk_o       (blk_idx_o),
    .bit_o       (bit_idx_o)
  );

  // Strobe period ends on the edge that latches the final bit (R6).
  a_r6_eof_then_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> (bit_idx_o == BIT_W'(BLOCK_BITS - 1)) && (blk_idx_o == BLK_W'(BLOCKS_PER_SF - 1))
              && (sf_idx_o == SF_W'(SUBFRAMES - 1)));

  a_r6_new_frame_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eof_o) |=> (bit_idx_o == '0) && (blk_idx_o == '0) && (sf_idx_o == '0) && oh_ind_o);
endmodule

// File: tb/tb_ds3_tx_serial_port.sv
module tb_ds3_tx_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser = 1'b0;
  logic eof, oh, vld, dat;
  logic [2:0] sf, blk;
  logic [6:0] bidx;

  int checks = 0;
  int errors = 0;
  int k = 0;        // edges since reset release
  int pat = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic last_in = 1'b0;

  always #4 clk = ~clk;

  ds3_tx_serial_port dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_data_i(ser),
    .eof_o(eof), .oh_ind_o(oh), .data_valid_o(vld), .data_o(dat),
    .sf_idx_o(sf), .blk_idx_o(blk), .bit_idx_o(bidx)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) k <= 0;
    else begin
      k <= k + 1;
      last_in <= ser;
    end
  end

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (k=%0d)", tag, act, exp_v, k);
    end
  endtask

  task automatic compare_all();
    int p, eb, ebk, esf, eeof;
    if (!rst_n || k == 0) begin
      chk("R1 eof", eof, 0); chk("R1 oh", oh, 0); chk("R1 valid", vld, 0);
      chk("R1 data", dat, 0); chk("R1 sf", sf, 0); chk("R1 blk", blk, 0);
      chk("R1 bit", bidx, 0);
      return;
    end
    p    = (k - 1) % 4760;
    eb   = p % 85;
    ebk  = (p / 85) % 8;
    esf  = p / 680;
    eeof = ((k % 4760) == 4759) ? 1 : 0;
    chk("R2 data", dat, last_in);
    chk("R3 bit", bidx, eb);
    chk("R3 blk", blk, ebk);
    chk("R3 sf", sf, esf);
    if (p == 0 && k > 1) chk("R4 wrap", {sf, blk, bidx} == 0 ? 1 : 0, 1);
    chk("R5 eof", eof, eeof);
    if (k % 4760 == 0) chk("R6 last bit after eof", (bidx == 84 && blk == 7 && sf == 6) ? 1 : 0, 1);
    if (k % 4760 == 1 && k > 1) chk("R6 first bit", bidx + blk + sf, 0);
    chk("R7 oh", oh, (eb == 0) ? 1 : 0);
    chk("R7 valid", vld, (eb != 0) ? 1 : 0);
    if (eb == 0) chk("R8 data at overhead", dat, last_in);
  endtask

  function automatic logic next_bit(int step);
    case (pat)
      0: return 1'b1;
      1: return 1'b0;
      2: return step[0];
      default: return lfsr[0];
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    compare_all();                    // R1 during reset
    rst_n = 1'b1;
    for (int i = 0; i < 9700; i++) begin
      @(negedge clk);
      compare_all();
      pat = (i / 500) % 4;
      if (pat == 3) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ser = next_bit(i);
    end
    // mid-frame reset, position must restart
    @(negedge clk);
    rst_n = 1'b0;
    ser = 1'b1;
    @(negedge clk);
    compare_all();                    // R1 after mid-run reset
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    for (int i = 0; i < 300; i++) begin
      ser = ~ser;
      @(negedge clk);
      compare_all();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule